// File: doc/BRIEF.md
# Adjustable Microframe Start-of-Frame Timer

This block paces a high-speed host bus schedule. It counts bit-time enables into a counter whose period is set by a small adjustment word, so that a clock source with a known frequency error can be trimmed back to the nominal microframe length. Each time the counter finishes a period it raises a one-cycle microframe strobe and advances a 3-bit microframe index. Every eighth strobe, the one that enters microframe 0, is also the 1 ms frame strobe.

A short-count mode exists for simulation runs. In that mode every microframe lasts a fixed, small number of bit times, so a full frame takes a fraction of its real length. The adjustment word and the mode select are both sampled only at a microframe boundary. A microframe that has already started always runs to the length it began with.

Top module: `uframe_sof_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its count, its index and both strobes. After `rst` falls, `uframe_tick` and `frame_tick` are 0 and `uframe_idx` is 0 until the first period completes.
- R2: In full mode a microframe lasts BASE_LEN + ADJ_STEP × adj enabled cycles. The defaults are 59488 and 16, so adj = 32 gives 60,000 bit times.
- R3: The count advances only on cycles where `bit_en` is 1. With `bit_en` held at 0, no strobe occurs and `uframe_idx` holds its value.
- R4: `frame_adj` is sampled at the edge that ends a microframe, and the sampled value sets the length of the microframe that follows. A change made part way through a microframe does not alter the length of that microframe.
- R5: After reset, the effective adjustment is 32 (nominal) and full mode is selected, whatever `frame_adj` and `sim_short` show. This setting holds until the first boundary.
- R6: When `sim_short` = 1 is sampled at a boundary, the following microframes last SIM_LEN enabled cycles each, and `frame_adj` has no effect on them. Sampling `sim_short` = 0 at a later boundary restores the full length.
- R7: `uframe_tick` is high for exactly one cycle. That cycle directly follows the enabled cycle that completes the period.
- R8: `uframe_idx` steps by one on each microframe strobe, wraps from 7 to 0, and stays constant between strobes.
- R9: `frame_tick` is high exactly when `uframe_tick` is high and `uframe_idx` has just become 0, which is once per eight microframes. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One bit time elapses on each cycle this is 1 |
| frame_adj | input | 6 | Period adjustment, sampled at each microframe boundary |
| sim_short | input | 1 | 1 selects the short simulation period, sampled at each boundary |
| uframe_tick | output | 1 | One-cycle start-of-microframe strobe |
| frame_tick | output | 1 | One-cycle start-of-frame strobe, coincident with the strobe into microframe 0 |
| uframe_idx | output | 3 | Index of the microframe now in progress |

## Verification
Every strobe and the index are registered once after the counter reaches its last value. So for a period of P enabled cycles, the strobe shows at the falling edge after the P-th enabled rising edge. The bench counts enabled rising edges in its own counter and compares the difference between two strobe sightings with P, always sampling at falling edges. A new adjustment or mode is driven between boundaries, and its effect is looked for only in the period after the next strobe. The index and frame strobe are checked at each strobe sighting against a model that advances on the strobes.

// File: rtl/sof_pkg.sv
package sof_pkg;

    localparam int ADJ_W = 6;
    localparam logic [ADJ_W-1:0] ADJ_NOMINAL = 6'd32;

    typedef struct packed {
        logic             sim;
        logic [ADJ_W-1:0] adj;
    } sof_cfg_t;

    localparam sof_cfg_t CFG_RESET = '{sim: 1'b0, adj: ADJ_NOMINAL};

    // Microframe length in enabled cycles for a given configuration.
    function automatic int unsigned uf_len(sof_cfg_t c, int unsigned base,
                                           int unsigned step, int unsigned sim_len);
        if (c.sim)
            return sim_len;
        return base + step * 32'(c.adj);
    endfunction

endpackage

// File: rtl/sof_cfg_hold.sv
module sof_cfg_hold
    import sof_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  sof_cfg_t nxt,
    output sof_cfg_t cur
);

    always_ff @(posedge clk) begin
        if (rst)
            cur <= CFG_RESET;
        else if (load)
            cur <= nxt;
    end

    // R4: the active setting only moves at a boundary
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cur));

    // R4: a boundary installs the value presented at that edge
    a_r4_cfg_load: assert property (@(posedge clk) disable iff (rst)
        load |=> cur == $past(nxt));

endmodule

// File: rtl/sof_bit_counter.sv
module sof_bit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic [CNT_W-1:0] last,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = bit_en && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (bit_en)
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // R2: the count never passes the last value of the active period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

    // R3: no enable, no progress
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(cnt_q));

endmodule

// File: rtl/sof_uframe_seq.sv
module sof_uframe_seq #(
    parameter int UF_PER_FRAME = 8,
    localparam int IDX_W = $clog2(UF_PER_FRAME)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    output logic             uf_tick,
    output logic             fr_tick,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(UF_PER_FRAME - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            uf_tick <= 1'b0;
            fr_tick <= 1'b0;
            idx     <= '0;
        end else begin
            uf_tick <= wrap;
            fr_tick <= wrap && (idx == IDX_LAST);
            if (wrap)
                idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
        end
    end

    // R7: strobe lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        uf_tick |=> !uf_tick);

    // R8: index moves one step per strobe, modulo the frame size
    a_r8_idx_step: assert property (@(posedge clk) disable iff (rst)
        uf_tick |-> idx == (($past(idx) == IDX_LAST) ? '0 : $past(idx) + 1'b1));

    // R8: index holds between strobes
    a_r8_idx_hold: assert property (@(posedge clk) disable iff (rst)
        !uf_tick |-> $stable(idx));

    // R9: frame strobe only with the strobe into microframe 0
    a_r9_frame_align: assert property (@(posedge clk) disable iff (rst)
        fr_tick |-> (uf_tick && idx == '0));

    a_r9_frame_present: assert property (@(posedge clk) disable iff (rst)
        (uf_tick && idx == '0) |-> fr_tick);

endmodule

// File: rtl/uframe_sof_timer.sv
module uframe_sof_timer
    import sof_pkg::*;
#(
    parameter int unsigned BASE_LEN     = 59488,
    parameter int unsigned ADJ_STEP     = 16,
    parameter int unsigned SIM_LEN      = 120,
    parameter int          UF_PER_FRAME = 8,
    localparam int         IDX_W        = $clog2(UF_PER_FRAME)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic [ADJ_W-1:0] frame_adj,
    input  logic             sim_short,
    output logic             uframe_tick,
    output logic             frame_tick,
    output logic [IDX_W-1:0] uframe_idx
);

    localparam int unsigned FULL_MAX = BASE_LEN + ADJ_STEP * ((1 << ADJ_W) - 1);
    localparam int unsigned MAX_LEN  = (FULL_MAX > SIM_LEN) ? FULL_MAX : SIM_LEN;
    localparam int          CNT_W    = $clog2(MAX_LEN);

    sof_cfg_t         cfg_cur;
    sof_cfg_t         cfg_nxt;
    logic             wrap;
    logic [CNT_W-1:0] last_w;

    assign cfg_nxt = '{sim: sim_short, adj: frame_adj};
    assign last_w  = CNT_W'(uf_len(cfg_cur, BASE_LEN, ADJ_STEP, SIM_LEN) - 1);

    sof_cfg_hold u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (wrap),
        .nxt  (cfg_nxt),
        .cur  (cfg_cur)
    );

    sof_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .last   (last_w),
        .wrap   (wrap)
    );

    sof_uframe_seq #(.UF_PER_FRAME(UF_PER_FRAME)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .uf_tick (uframe_tick),
        .fr_tick (frame_tick),
        .idx     (uframe_idx)
    );

    // R7: a strobe is always the registered image of a completed period
    a_r7_tick_follows_wrap: assert property (@(posedge clk) disable iff (rst)
        wrap |=> uframe_tick);

    // R1: no strobe in the first cycle after reset release
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!uframe_tick && !frame_tick && uframe_idx == '0));

endmodule

// File: tb/uframe_sof_timer_bench.sv
`timescale 1ns/1ps
module uframe_sof_timer_bench;

    localparam int unsigned B_BASE = 40;
    localparam int unsigned B_STEP = 2;
    localparam int unsigned B_SIM  = 12;

    typedef struct packed {
        logic [5:0]  adj;
        logic        sim;
        int unsigned len;
    } vec_t;

    // adj, sim, expected length in enabled cycles (B_BASE + B_STEP*adj or B_SIM)
    localparam vec_t VECS [8] = '{
        '{6'd32, 1'b0, 104},
        '{6'd0,  1'b0, 40},
        '{6'd63, 1'b0, 166},
        '{6'd1,  1'b0, 42},
        '{6'd17, 1'b0, 74},
        '{6'd5,  1'b1, 12},
        '{6'd63, 1'b1, 12},
        '{6'd32, 1'b0, 104}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       d_rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       sim = 1'b0;
    logic [5:0] adj = 6'd32;
    logic       uf_tick, fr_tick, d_tick, d_fr;
    logic [2:0] uf_idx, d_idx;

    int          errs = 0;
    int          checks = 0;
    int unsigned en_cnt = 0;
    int unsigned d_en = 0;
    bit          d_done = 1'b0;
    int          frames_seen = 0;

    always #2.5 clk = ~clk;

    uframe_sof_timer #(.BASE_LEN(B_BASE), .ADJ_STEP(B_STEP), .SIM_LEN(B_SIM)) u_uframe_sof_timer (
        .clk(clk), .rst(rst), .bit_en(bit_en), .frame_adj(adj), .sim_short(sim),
        .uframe_tick(uf_tick), .frame_tick(fr_tick), .uframe_idx(uf_idx)
    );

    uframe_sof_timer u_uframe_sof_timer_dflt (
        .clk(clk), .rst(d_rst), .bit_en(1'b1), .frame_adj(6'd32), .sim_short(1'b0),
        .uframe_tick(d_tick), .frame_tick(d_fr), .uframe_idx(d_idx)
    );

    always @(posedge clk) begin
        if (!rst && bit_en) en_cnt <= en_cnt + 1;
        if (!d_rst) d_en <= d_en + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 at default parameters: nominal adjustment gives 60000 bit times
    always @(negedge clk) begin
        if (!d_rst && !d_done && d_tick) begin
            check(d_en == 60000, "R2 default length", int'(d_en), 60000);
            check(d_idx == 3'd1 && !d_fr, "R8 default first index", int'(d_idx), 1);
            d_done = 1'b1;
        end
    end

    // Index and frame-strobe model, advanced on each observed strobe
    int unsigned exp_idx = 0;
    bit          prev_tick = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            exp_idx   = 0;
            prev_tick = 1'b0;
        end else begin
            if (uf_tick) begin
                exp_idx = (exp_idx + 1) % 8;
                check(int'(uf_idx) == int'(exp_idx), "R8 index step", int'(uf_idx), int'(exp_idx));
                check(fr_tick == (exp_idx == 0), "R9 frame strobe", int'(fr_tick), int'(exp_idx == 0));
                check(!prev_tick, "R7 single-cycle strobe", int'(prev_tick), 0);
                if (fr_tick) frames_seen++;
            end else if (fr_tick) begin
                check(1'b0, "R9 frame strobe without microframe strobe", 1, 0);
            end
            prev_tick = uf_tick;
        end
    end

    task automatic wait_tick();
        forever begin
            @(negedge clk);
            if (uf_tick) break;
        end
    endtask

    task automatic next_period(output int unsigned p);
        int unsigned e0;
        e0 = en_cnt;
        wait_tick();
        p = en_cnt - e0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned p;
        int unsigned e0;
        int          cyc;
        logic [2:0]  idx_hold;

        // R1: reset state, with a non-nominal adjustment already presented
        adj = 6'd0;
        repeat (4) @(negedge clk);
        check(!uf_tick && !fr_tick && uf_idx == 3'd0, "R1 reset outputs",
              int'({uf_tick, fr_tick, uf_idx}), 0);
        rst = 1'b0;
        d_rst = 1'b0;
        bit_en = 1'b1;

        // R5: first microframe uses the nominal value, not the presented 0
        e0 = en_cnt;
        wait_tick();
        check(en_cnt - e0 == 104, "R5 first length after reset", int'(en_cnt - e0), 104);
        next_period(p);
        check(p == 40, "R4 value sampled at first boundary", int'(p), 40);

        // Table of settings: R2 for full mode, R6 for short mode
        foreach (VECS[i]) begin
            adj = VECS[i].adj;
            sim = VECS[i].sim;
            wait_tick();
            next_period(p);
            check(p == VECS[i].len, VECS[i].sim ? "R6 short length" : "R2 adjusted length",
                  int'(p), int'(VECS[i].len));
        end

        // R4: change part way through a microframe
        adj = 6'd0;
        sim = 1'b0;
        wait_tick();
        e0 = en_cnt;
        repeat (10) @(negedge clk);
        adj = 6'd63;
        wait_tick();
        check(en_cnt - e0 == 40, "R4 running microframe unchanged", int'(en_cnt - e0), 40);
        next_period(p);
        check(p == 166, "R4 new value at next microframe", int'(p), 166);

        // R3: alternate enables, period counts only enabled cycles
        adj = 6'd0;
        wait_tick();
        wait_tick();
        e0 = en_cnt;
        bit_en = 1'b0;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (uf_tick || cyc > 1000) break;
            bit_en = ~bit_en;
        end
        check(cyc == 80, "R3 cycles with alternate enable", cyc, 80);
        check(en_cnt - e0 == 40, "R3 enabled cycles counted", int'(en_cnt - e0), 40);

        // R3: enable held low, nothing moves
        bit_en = 1'b0;
        idx_hold = uf_idx;
        cyc = 0;
        repeat (300) begin
            @(negedge clk);
            if (uf_tick) cyc++;
        end
        check(cyc == 0, "R3 no strobe without enable", cyc, 0);
        check(uf_idx == idx_hold, "R3 index held", int'(uf_idx), int'(idx_hold));
        bit_en = 1'b1;

        // R1 and R5: reset in mid run, short mode and adjustment presented
        repeat (17) @(negedge clk);
        adj = 6'd63;
        sim = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!uf_tick && !fr_tick && uf_idx == 3'd0, "R1 mid-run reset outputs",
              int'({uf_tick, fr_tick, uf_idx}), 0);
        rst = 1'b0;
        e0 = en_cnt;
        wait_tick();
        check(en_cnt - e0 == 104, "R5 nominal full length after reset", int'(en_cnt - e0), 104);
        sim = 1'b0;
        next_period(p);
        check(p == B_SIM, "R6 short mode from first boundary", int'(p), int'(B_SIM));
        next_period(p);
        check(p == 166, "R6 full mode restored", int'(p), 166);

        check(frames_seen > 0, "R9 frame strobe observed", frames_seen, 1);

        while (!d_done) @(negedge clk);
        finish_run();
    end

endmodule